// File: doc/BRIEF.md
# Sized Port Output Unit

This unit carries out port-output operations of byte, halfword and word size for a 32-bit core. The pipeline gives it a base register value, a signed 16-bit displacement, a source data register value and a size code, together with a one-cycle start strobe. The unit adds the sign-extended displacement to the base to form an unsigned port address. It clears the low address bits that the access size makes meaningless, so a misaligned address is forced into alignment and never raises a fault.

The unit then issues one single-beat port write. The write carries the aligned address, the little-endian byte enables and the source bytes placed on the byte lanes those enables select. A valid/ready handshake carries the write. One cycle after the handshake completes, the unit pulses a completion strobe back to the pipeline. Port output changes no condition flags, so the unit has no flag interface.

Top module: `sized_port_out`

## Requirements
- R1: After reset, `pw_valid_o` and `done_o` are low.
- R2: The port address is `base_i` plus `disp_i` sign-extended to 32 bits. The sum wraps modulo 2^32 and raises no error.
- R3: Size code 2'b00 is a byte access. The address is left unmasked, `pw_be_o` has only bit addr[1:0] set, and the low byte of `data_i` is repeated on all four lanes of `pw_data_o`.
- R4: Size code 2'b01 is a halfword access. Address bit 0 is forced to 0. `pw_be_o` is 4'b0011 when addr[1] is 0 and 4'b1100 when it is 1, and the low halfword of `data_i` is repeated on both halves of `pw_data_o`.
- R5: Size code 2'b10 is a word access. Address bits 1:0 are forced to 0, `pw_be_o` is 4'b1111 and `pw_data_o` equals `data_i`.
- R6: Size code 2'b11 behaves exactly as a word access.
- R7: A start that is accepted at a clock edge makes `pw_valid_o` high in the following cycle. While valid is high and `pw_ready_i` is low, address, enables and data hold stable.
- R8: At the edge where valid and ready are both high, valid falls. `done_o` is high for exactly the following cycle.
- R9: A start strobe while `pw_valid_o` is high is ignored. The pending write keeps its address, enables and data.
- R10: `pw_ready_i` asserted while no write is pending produces no completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for one output operation |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| data_i | input | 32 | Source data register value |
| pw_ready_i | input | 1 | Port write accepted by the bus |
| pw_valid_o | output | 1 | Port write pending |
| pw_addr_o | output | 32 | Aligned port address |
| pw_be_o | output | 4 | Byte enables, bit n selects lane n |
| pw_data_o | output | 32 | Lane-aligned write data |
| done_o | output | 1 | Completion pulse to the pipeline |

## Verification
The bench places a byte at each of the four lane offsets and halfwords at odd and even addresses. A wrong enable decode or lane mapping would show up there as a byte on the wrong lane or a halfword that straddles the word. A negative displacement applied to an unaligned base, and a sum that crosses 2^32, check the sign extension and the wraparound; a zero-extended or saturating adder would give a different address. The bench holds ready low for several cycles and pulses start during that stall. A design that re-captures its inputs would change the pending payload. The bench also pulses ready while idle, to catch a completion strobe that fires without a write.

// File: rtl/pout_pkg.sv
package pout_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WIDE = 2'b11
   } pout_size_e;

   // log2 of the access width in lanes, clipped to the bus width
   function automatic int size_shift(input logic [1:0] sz, input int max_shift);
      int s;
      case (sz)
         SZ_BYTE: s = 0;
         SZ_HALF: s = 1;
         default: s = 2;
      endcase
      if (s > max_shift) s = max_shift;
      return s;
   endfunction

endpackage

// File: rtl/pout_addr_gen.sv
module pout_addr_gen
   import pout_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int SEL_W  = 2
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [1:0]        size_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int EXT_W = ADDR_W - DISP_W;

   generate
      if (DISP_W >= ADDR_W) begin : g_bad_disp
         $error("pout_addr_gen: DISP_W must be narrower than ADDR_W");
      end
      if (SEL_W >= ADDR_W) begin : g_bad_sel
         $error("pout_addr_gen: SEL_W too large");
      end
   endgenerate

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] raw_sum;

   assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
   assign raw_sum  = base_i + disp_ext;   // modulo 2^ADDR_W

   always_comb begin
      int sh;
      sh     = size_shift(size_i, SEL_W);
      addr_o = raw_sum;
      for (int b = 0; b < SEL_W; b++) begin
         if (b < sh) addr_o[b] = 1'b0;
      end
   end

endmodule

// File: rtl/pout_lane_steer.sv
module pout_lane_steer
   import pout_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int LANE_W    = 8,
   parameter bit REPLICATE = 1'b1
) (
   input  logic [$clog2(DATA_W/LANE_W)-1:0] lane_i,
   input  logic [1:0]                       size_i,
   input  logic [DATA_W-1:0]                data_i,
   output logic [DATA_W/LANE_W-1:0]         be_o,
   output logic [DATA_W-1:0]                data_o
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int SEL_W = $clog2(LANES);

   generate
      if (DATA_W % LANE_W != 0) begin : g_bad_lane
         $error("pout_lane_steer: DATA_W must be a multiple of LANE_W");
      end
      if (LANES < 2 || LANES > 8 || (1 << SEL_W) != LANES) begin : g_bad_lanes
         $error("pout_lane_steer: lane count must be 2, 4 or 8");
      end
   endgenerate

   int sh;
   int lo;

   always_comb begin
      sh = size_shift(size_i, SEL_W);
      lo = int'(lane_i);
   end

   // byte enables: lanes in the same aligned group as the address
   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         be_o[l] = ((l >> sh) == (lo >> sh));
      end
   end

   generate
      if (REPLICATE) begin : g_replicate
         // the low access-sized slice is repeated across the bus
         always_comb begin
            for (int l = 0; l < LANES; l++) begin
               int idx;
               idx = l & ((1 << sh) - 1);
               data_o[l*LANE_W +: LANE_W] = data_i[idx*LANE_W +: LANE_W];
            end
         end
      end else begin : g_shift
         // the slice is placed on the enabled lanes, others are zero
         always_comb begin
            for (int l = 0; l < LANES; l++) begin
               int idx;
               idx = (l - lo) & (LANES - 1);
               if ((l >> sh) == (lo >> sh))
                  data_o[l*LANE_W +: LANE_W] = data_i[idx*LANE_W +: LANE_W];
               else
                  data_o[l*LANE_W +: LANE_W] = '0;
            end
         end
      end
   endgenerate

   always_comb begin
      a_be_count_r3: assert (($countones(be_o) == (1 << sh)) || $isunknown(size_i))
         else $error("byte enable count does not match access size");
   end

endmodule

// File: rtl/pout_req_reg.sv
module pout_req_reg #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int BE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BE_W-1:0]   be_o,
   output logic [DATA_W-1:0] data_o,
   output logic              done_o
);
   logic accept;
   logic fire;

   assign accept = start_i && !valid_o;
   assign fire   = valid_o && ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= fire;
         if (accept)    valid_o <= 1'b1;
         else if (fire) valid_o <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_o <= '0;
         be_o   <= '0;
         data_o <= '0;
      end else if (accept) begin
         addr_o <= addr_i;
         be_o   <= be_i;
         data_o <= data_i;
      end
   end

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(be_o) && $stable(data_o));

   p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !valid_o |=> valid_o);

   p_done_after_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && ready_i |=> done_o && !valid_o);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_no_spurious_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |=> !done_o);

endmodule

// File: rtl/sized_port_out.sv
module sized_port_out
   import pout_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DISP_W    = 16,
   parameter int DATA_W    = 32,
   parameter int LANE_W    = 8,
   parameter bit REPLICATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [1:0]                 size_i,
   input  logic [ADDR_W-1:0]          base_i,
   input  logic [DISP_W-1:0]          disp_i,
   input  logic [DATA_W-1:0]          data_i,
   input  logic                       pw_ready_i,
   output logic                       pw_valid_o,
   output logic [ADDR_W-1:0]          pw_addr_o,
   output logic [DATA_W/LANE_W-1:0]   pw_be_o,
   output logic [DATA_W-1:0]          pw_data_o,
   output logic                       done_o
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int SEL_W = $clog2(LANES);

   logic [ADDR_W-1:0] addr_c;
   logic [LANES-1:0]  be_c;
   logic [DATA_W-1:0] data_c;

   pout_addr_gen #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W),
      .SEL_W  (SEL_W)
   ) u_addr (
      .base_i (base_i),
      .disp_i (disp_i),
      .size_i (size_i),
      .addr_o (addr_c)
   );

   pout_lane_steer #(
      .DATA_W    (DATA_W),
      .LANE_W    (LANE_W),
      .REPLICATE (REPLICATE)
   ) u_steer (
      .lane_i (addr_c[SEL_W-1:0]),
      .size_i (size_i),
      .data_i (data_i),
      .be_o   (be_c),
      .data_o (data_c)
   );

   pout_req_reg #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BE_W   (LANES)
   ) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .addr_i  (addr_c),
      .be_i    (be_c),
      .data_i  (data_c),
      .ready_i (pw_ready_i),
      .valid_o (pw_valid_o),
      .addr_o  (pw_addr_o),
      .be_o    (pw_be_o),
      .data_o  (pw_data_o),
      .done_o  (done_o)
   );

   p_word_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pw_valid_o && (&pw_be_o) |-> pw_addr_o[SEL_W-1:0] == '0);

   p_be_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pw_valid_o |-> pw_be_o != '0);

endmodule

// File: tb/sized_port_out_test.sv
module sized_port_out_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  size_i = 2'b00;
   logic [31:0] base_i = '0;
   logic [15:0] disp_i = '0;
   logic [31:0] data_i = '0;
   logic        pw_ready_i = 1'b0;
   logic        pw_valid_o;
   logic [31:0] pw_addr_o;
   logic [3:0]  pw_be_o;
   logic [31:0] pw_data_o;
   logic        done_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   sized_port_out uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
      .base_i(base_i), .disp_i(disp_i), .data_i(data_i),
      .pw_ready_i(pw_ready_i), .pw_valid_o(pw_valid_o), .pw_addr_o(pw_addr_o),
      .pw_be_o(pw_be_o), .pw_data_o(pw_data_o), .done_o(done_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // expected values built from the requirement text
   task automatic expect_req(input logic [31:0] b, input logic [15:0] d,
                             input logic [31:0] v, input logic [1:0] sz,
                             output logic [31:0] ea, output logic [3:0] ebe,
                             output logic [31:0] ed);
      logic [31:0] sum;
      sum = b + {{16{d[15]}}, d};
      case (sz)
         2'b00: begin
            ea = sum;
            ebe = 4'b0001 << sum[1:0];
            ed = {4{v[7:0]}};
         end
         2'b01: begin
            ea = {sum[31:1], 1'b0};
            ebe = sum[1] ? 4'b1100 : 4'b0011;
            ed = {2{v[15:0]}};
         end
         default: begin
            ea = {sum[31:2], 2'b00};
            ebe = 4'b1111;
            ed = v;
         end
      endcase
   endtask

   // issue one operation, optionally stall, then complete it
   task automatic run_op(input string req, input logic [31:0] b, input logic [15:0] d,
                         input logic [31:0] v, input logic [1:0] sz, input int stall,
                         input bit poke);
      logic [31:0] ea, ed;
      logic [3:0]  ebe;
      expect_req(b, d, v, sz, ea, ebe, ed);
      @(negedge clk);
      start_i = 1'b1; base_i = b; disp_i = d; data_i = v; size_i = sz;
      @(negedge clk);
      start_i = 1'b0;
      base_i = ~b; data_i = ~v;
      check("R7", "valid after start", {31'b0, pw_valid_o}, 32'd1);
      check(req, "addr", pw_addr_o, ea);
      check(req, "be", {28'b0, pw_be_o}, {28'b0, ebe});
      check(req, "data", pw_data_o, ed);
      for (int i = 0; i < stall; i++) begin
         if (poke) begin
            start_i = 1'b1; size_i = 2'b00; disp_i = 16'h0011;
         end
         @(negedge clk);
         start_i = 1'b0;
         check("R7", "valid held", {31'b0, pw_valid_o}, 32'd1);
         check(poke ? "R9" : "R7", "addr held", pw_addr_o, ea);
         check(poke ? "R9" : "R7", "be held", {28'b0, pw_be_o}, {28'b0, ebe});
         check(poke ? "R9" : "R7", "data held", pw_data_o, ed);
         check("R8", "no early done", {31'b0, done_o}, 32'd0);
      end
      pw_ready_i = 1'b1;
      @(negedge clk);
      pw_ready_i = 1'b0;
      check("R8", "valid drops", {31'b0, pw_valid_o}, 32'd0);
      check("R8", "done pulse", {31'b0, done_o}, 32'd1);
      @(negedge clk);
      check("R8", "done one cycle", {31'b0, done_o}, 32'd0);
   endtask

   task automatic test_reset;
      check("R1", "valid at reset", {31'b0, pw_valid_o}, 32'd0);
      check("R1", "done at reset", {31'b0, done_o}, 32'd0);
   endtask

   task automatic test_idle_ready;
      pw_ready_i = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R10", "no done while idle", {31'b0, done_o}, 32'd0);
         check("R10", "no valid while idle", {31'b0, pw_valid_o}, 32'd0);
      end
      pw_ready_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      // R3 byte at every lane
      for (int k = 0; k < 4; k++)
         run_op("R3", 32'h0000_1000 + k, 16'h0000, 32'hA1B2_C3D4, 2'b00, 0, 1'b0);
      // R4 halfwords at odd and even offsets
      run_op("R4", 32'h0000_1003, 16'h0000, 32'h1234_5678, 2'b01, 0, 1'b0);
      run_op("R4", 32'h0000_1001, 16'h0000, 32'hCAFE_BEEF, 2'b01, 0, 1'b0);
      // R5 word, negative displacement on unaligned base (R2)
      run_op("R5", 32'h0000_2003, 16'hFFFE, 32'hDEAD_BEEF, 2'b10, 0, 1'b0);
      run_op("R2", 32'h0000_0010, 16'h8000, 32'h0102_0304, 2'b00, 0, 1'b0);
      // R2 wrap past 2^32
      run_op("R2", 32'hFFFF_FFF0, 16'h0021, 32'h5566_7788, 2'b00, 0, 1'b0);
      // R6 reserved size acts as word
      run_op("R6", 32'h0000_3007, 16'h0002, 32'h0BAD_F00D, 2'b11, 0, 1'b0);
      // R7 stall with ready low
      run_op("R7", 32'h0000_4001, 16'h0004, 32'h1111_2222, 2'b01, 3, 1'b0);
      // R9 start pulses during stall
      run_op("R9", 32'h0000_5002, 16'h0000, 32'h9988_7766, 2'b00, 3, 1'b1);
      // R10 ready while idle
      test_idle_ready();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule